// File: doc/BRIEF.md
# Programmable MMIO Window Router

This block sits on the CPU side of an I/O hub and steers memory-mapped accesses to one of four downstream bridge ports. Software programs four direct windows. Each window is described by three 64-bit registers: a base, a mask and a route. For every incoming access address the block reports, in the same cycle, whether a window claims it, which port it goes to and the byte offset from the start of that window. An access that neither hits a window nor lands on a register raises a decode error.

The range registers sit in a 4 KiB register page. Their byte offsets are 0x300 + 8*i for i = 0..26. Window k uses register indices 3k, 3k+1 and 3k+2. The indices above the direct windows hold fixed distributed-range settings. These are only reset values and do not take part in the decode. Each register can be written as a full 64-bit word or as either 32-bit half. The access port is a single valid-qualified channel with no back-pressure: the block accepts every valid access in the cycle it is presented.

Top module: `mwr_router`

## Requirements
- R1: After reset, index 13 reads 0x00000000fc000000, index 19 reads 0x000000ffffff0000, index 24 reads 0x000000fffee00000 and index 25 reads 0x000000ffffff0000. Every other range register reads zero.
- R2: A wide (64-bit) write to a register offset replaces the whole register. A wide read returns all 64 bits.
- R3: A narrow (32-bit) write takes its data from wdata[31:0]. With address bit 2 set it replaces bits 63:32, and with bit 2 clear it replaces bits 31:0. The other half keeps its value.
- R4: A narrow read returns the half selected by address bit 2 (1 = upper, 0 = lower), zero-extended to 64 bits.
- R5: Bit 0 of window k's base register enables the window. A window with this bit clear never hits.
- R6: Window size is (~mask[31:0] + 1) mod 2^32 with bits 11:0 cleared. A window whose size is zero never hits.
- R7: The effective base is {32'hffffffff, base[31:12], 12'h000}. An address hits window k when base <= addr < base + size, compared on the full 64-bit address.
- R8: On a hit, win_port equals the window's route[1:0] and win_offset equals addr minus the effective base. Without a hit, both outputs are zero.
- R9: When several windows hit, the lowest-numbered window wins.
- R10: acc_reg_hit is high when a valid access lies in the register page at byte offset 0x300..0x3d7. dec_err is high for a valid access that hits neither a register nor a window. A write to a non-register address changes no register.
- R11: Register writes take effect at the next clock edge. The decode outputs and acc_rdata are combinational in the same cycle. Without acc_valid and acc_write together, no register changes, and with acc_valid low, win_hit and dec_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_addr | input | 64 | Access byte address |
| acc_wdata | input | 64 | Write data (narrow writes use bits 31:0) |
| acc_rdata | output | 64 | Register read data, zero when no register is hit |
| acc_reg_hit | output | 1 | Access addresses a range register |
| win_hit | output | 1 | Access falls inside an enabled window |
| win_port | output | 2 | Downstream port chosen by the winning window |
| win_offset | output | 64 | Offset of the address from the winning window's base |
| dec_err | output | 1 | Valid access matched no register and no window |

## Verification
Every decode output and the read data are combinational in the access cycle. The bench therefore drives each access just after a falling edge and samples 2 ns later, before the next rising edge. A register write lands on the rising edge that follows the falling edge where it was driven. Any check that depends on that write is made only after the input has dropped at the next falling edge, which is one cycle later. The window probes sweep each window's first byte, last byte and both neighbouring bytes across several window sets. Expected hit, port, offset and error values come from a shadow copy of the registers kept by the bench.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  // Range registers live at byte offset RANGE_BYTE_OFF of a 4 KiB page,
  // one 64-bit register every 8 bytes.
  localparam int unsigned PAGE_BITS      = 12;
  localparam int unsigned RANGE_BYTE_OFF = 'h300;
  localparam int unsigned REGS_PER_WIN   = 3;

  // Indices of the fixed distributed-range settings that reset non-zero.
  localparam int unsigned IDX_DIST_MASK   = 13;
  localparam int unsigned IDX_IODIST_MASK = 19;
  localparam int unsigned IDX_IODIR_BASE  = 24;
  localparam int unsigned IDX_IODIR_MASK  = 25;

  typedef logic [63:0] word_t;

  function automatic word_t range_reset_value(int unsigned idx);
    word_t v;
    case (idx)
      IDX_DIST_MASK:   v = 64'h0000_0000_fc00_0000;
      IDX_IODIST_MASK: v = 64'h0000_00ff_ffff_0000;
      IDX_IODIR_BASE:  v = 64'h0000_00ff_fee0_0000;
      IDX_IODIR_MASK:  v = 64'h0000_00ff_ffff_0000;
      default:         v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mwr_regfile.sv
module mwr_regfile #(
  parameter int unsigned NUM_REGS   = 27,
  parameter int unsigned NUM_WIN    = 4,
  parameter int unsigned PORT_W     = 2,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic                              wr_wide,
  input  logic                              wr_hi,
  input  logic [63:0]                       wr_data,
  input  logic [IDX_W-1:0]                  rd_idx,
  input  logic                              rd_wide,
  input  logic                              rd_hi,
  output logic [63:0]                       rd_data,
  output logic [NUM_WIN-1:0]                base_en,
  output logic [NUM_WIN-1:0][31-PAGE_SHIFT:0] base_pg,
  output logic [NUM_WIN-1:0][31:0]          mask_lo,
  output logic [NUM_WIN-1:0][PORT_W-1:0]    route_sel
);

  logic [63:0] q [NUM_REGS];
  logic [63:0] rd_q;

  // Storage with full or half-word update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) q[i] <= mwr_pkg::range_reset_value(i);
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          if (wr_wide)    q[i]         <= wr_data;
          else if (wr_hi) q[i][63:32]  <= wr_data[31:0];
          else            q[i][31:0]   <= wr_data[31:0];
        end
      end
    end
  end

  // Read mux and half selection.
  always_comb begin
    rd_q = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == IDX_W'(i)) rd_q = q[i];
    if (rd_wide)    rd_data = rd_q;
    else if (rd_hi) rd_data = {32'h0, rd_q[63:32]};
    else            rd_data = {32'h0, rd_q[31:0]};
  end

  // Fields the window logic consumes.
  always_comb begin
    for (int w = 0; w < NUM_WIN; w++) begin
      base_en[w]   = q[mwr_pkg::REGS_PER_WIN*w][0];
      base_pg[w]   = q[mwr_pkg::REGS_PER_WIN*w][31:PAGE_SHIFT];
      mask_lo[w]   = q[mwr_pkg::REGS_PER_WIN*w+1][31:0];
      route_sel[w] = q[mwr_pkg::REGS_PER_WIN*w+2][PORT_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i) && !wr_wide && !wr_hi) |=> $stable(q[i][63:32])); // R3
    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i) && !wr_wide && wr_hi) |=> $stable(q[i][31:0])); // R3
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q[i])); // R11
  end

endmodule

// File: rtl/mwr_window_calc.sv
module mwr_window_calc #(
  parameter int unsigned PORT_W     = 2,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic                    base_en,
  input  logic [31-PAGE_SHIFT:0]  base_pg,
  input  logic [31:0]             mask_lo,
  input  logic [PORT_W-1:0]       route_sel,
  input  logic [63:0]             addr,
  output logic                    en,
  output logic [63:0]             base_al,
  output logic [31:0]             size,
  output logic                    match,
  output logic [PORT_W-1:0]       port,
  output logic [63:0]             offset
);

  localparam logic [31:0] PG_KEEP = {32{1'b1}} << PAGE_SHIFT;

  logic [31:0] size_raw;
  logic [63:0] rel;

  always_comb begin
    size_raw = ~mask_lo + 32'd1;
    size     = size_raw & PG_KEEP;
    base_al  = {32'hffff_ffff, base_pg, {PAGE_SHIFT{1'b0}}};
    en       = base_en;
    rel      = addr - base_al;
    match    = base_en && (size != 32'd0) && (addr >= base_al) && (rel < {32'h0, size});
    port     = route_sel;
    offset   = rel;
  end

endmodule

// File: rtl/mwr_pick.sv
module mwr_pick #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned PORT_W  = 2,
  localparam int unsigned SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0]             match,
  input  logic [NUM_WIN-1:0][PORT_W-1:0] ports,
  input  logic [NUM_WIN-1:0][63:0]       offsets,
  output logic                           hit,
  output logic [NUM_WIN-1:0]             grant,
  output logic [PORT_W-1:0]              port,
  output logic [63:0]                    offset
);

  logic [SEL_W-1:0] sel;

  // Scan downward so the lowest matching index is the last assignment.
  always_comb begin
    sel = '0;
    for (int k = NUM_WIN - 1; k >= 0; k--)
      if (match[k]) sel = SEL_W'(k);
    hit    = |match;
    grant  = '0;
    port   = '0;
    offset = '0;
    if (hit) begin
      grant[sel] = 1'b1;
      port       = ports[sel];
      offset     = offsets[sel];
    end
  end

endmodule

// File: rtl/mwr_router.sv
module mwr_router #(
  parameter int unsigned NUM_WIN    = 4,
  parameter int unsigned NUM_REGS   = 27,
  parameter int unsigned PORT_W     = 2,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter logic [63:0] REG_PAGE   = 64'hffff_ffff_fed0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               acc_wide,
  input  logic [63:0]        acc_addr,
  input  logic [63:0]        acc_wdata,
  output logic [63:0]        acc_rdata,
  output logic               acc_reg_hit,
  output logic               win_hit,
  output logic [PORT_W-1:0]  win_port,
  output logic [63:0]        win_offset,
  output logic               dec_err
);

  localparam int unsigned IDX_W   = $clog2(NUM_REGS);
  localparam int unsigned PB      = mwr_pkg::PAGE_BITS;
  localparam logic [PB-4:0] FIRST_WORD = (PB-3)'(mwr_pkg::RANGE_BYTE_OFF >> 3);
  localparam logic [PB-4:0] END_WORD   = (PB-3)'((mwr_pkg::RANGE_BYTE_OFF >> 3) + NUM_REGS);

  // Register page decode.
  logic             page_hit;
  logic [PB-4:0]    word;
  logic             in_rng;
  logic [IDX_W-1:0] reg_idx;
  logic [63:0]      rd_data;

  always_comb begin
    page_hit    = acc_addr[63:PB] == REG_PAGE[63:PB];
    word        = acc_addr[PB-1:3];
    in_rng      = (word >= FIRST_WORD) && (word < END_WORD);
    reg_idx     = IDX_W'(word - FIRST_WORD);
    acc_reg_hit = acc_valid && page_hit && in_rng;
    acc_rdata   = acc_reg_hit ? rd_data : 64'h0;
  end

  logic [NUM_WIN-1:0]                  base_en;
  logic [NUM_WIN-1:0][31-PAGE_SHIFT:0] base_pg;
  logic [NUM_WIN-1:0][31:0]            mask_lo;
  logic [NUM_WIN-1:0][PORT_W-1:0]      route_sel;

  mwr_regfile #(
    .NUM_REGS  (NUM_REGS),
    .NUM_WIN   (NUM_WIN),
    .PORT_W    (PORT_W),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_reg_hit && acc_write),
    .wr_idx   (reg_idx),
    .wr_wide  (acc_wide),
    .wr_hi    (acc_addr[2]),
    .wr_data  (acc_wdata),
    .rd_idx   (reg_idx),
    .rd_wide  (acc_wide),
    .rd_hi    (acc_addr[2]),
    .rd_data  (rd_data),
    .base_en  (base_en),
    .base_pg  (base_pg),
    .mask_lo  (mask_lo),
    .route_sel(route_sel)
  );

  // Per-window geometry and match.
  logic [NUM_WIN-1:0]             en_vec;
  logic [NUM_WIN-1:0]             match_vec;
  logic [NUM_WIN-1:0][63:0]       base_arr;
  logic [NUM_WIN-1:0][31:0]       size_arr;
  logic [NUM_WIN-1:0][PORT_W-1:0] port_arr;
  logic [NUM_WIN-1:0][63:0]       off_arr;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    mwr_window_calc #(
      .PORT_W    (PORT_W),
      .PAGE_SHIFT(PAGE_SHIFT)
    ) i_calc (
      .base_en  (base_en[w]),
      .base_pg  (base_pg[w]),
      .mask_lo  (mask_lo[w]),
      .route_sel(route_sel[w]),
      .addr     (acc_addr),
      .en       (en_vec[w]),
      .base_al  (base_arr[w]),
      .size     (size_arr[w]),
      .match    (match_vec[w]),
      .port     (port_arr[w]),
      .offset   (off_arr[w])
    );
  end

  logic [NUM_WIN-1:0] grant;
  logic [NUM_WIN-1:0] match_g;

  assign match_g = match_vec & {NUM_WIN{acc_valid}};

  mwr_pick #(
    .NUM_WIN(NUM_WIN),
    .PORT_W (PORT_W)
  ) i_pick (
    .match  (match_g),
    .ports  (port_arr),
    .offsets(off_arr),
    .hit    (win_hit),
    .grant  (grant),
    .port   (win_port),
    .offset (win_offset)
  );

  assign dec_err = acc_valid && !acc_reg_hit && !win_hit;

  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> |(grant & en_vec)); // R5
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!win_hit && !dec_err && !acc_reg_hit)); // R11

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_chk
    localparam logic [NUM_WIN-1:0] LOWER = NUM_WIN'((64'd1 << w) - 64'd1);
    AST_OFFSET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      grant[w] |-> (win_offset < {32'h0, size_arr[w]} && acc_addr >= base_arr[w])); // R8
    AST_LOWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      grant[w] |-> ((match_g & LOWER) == '0)); // R9
  end

endmodule

// File: tb/test_mwr_router.sv
module test_mwr_router;

  localparam logic [63:0] PAGE = 64'hffff_ffff_fed0_0000;
  localparam int NREG = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
  logic [63:0] acc_addr = '0, acc_wdata = '0;
  logic [63:0] acc_rdata, win_offset;
  logic        acc_reg_hit, win_hit, dec_err;
  logic [1:0]  win_port;

  int total = 0;
  int bad   = 0;
  logic [63:0] sh [NREG];

  always #4 clk = ~clk;

  mwr_router i_mwr_router (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_reg_hit(acc_reg_hit), .win_hit(win_hit),
    .win_port(win_port), .win_offset(win_offset), .dec_err(dec_err)
  );

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] roff(int i);
    return PAGE + 64'h300 + 64'(8 * i);
  endfunction

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_wide = 1'b0;
  endtask

  task automatic wr(logic [63:0] a, logic wide, logic [63:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_wide = wide;
    acc_addr = a; acc_wdata = d;
    idle();
  endtask

  // Shadow update per R2/R3, for register index i.
  task automatic wr_reg(int i, logic wide, logic hi, logic [63:0] d);
    wr(roff(i) + (hi ? 64'd4 : 64'd0), wide, d);
    if (wide) sh[i] = d;
    else if (hi) sh[i][63:32] = d[31:0];
    else sh[i][31:0] = d[31:0];
  endtask

  task automatic rd(logic [63:0] a, logic wide, output logic [63:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_wide = wide; acc_addr = a;
    #2 d = acc_rdata;
  endtask

  // Bench model of the decode (R5..R10).
  task automatic model(logic [63:0] a, output logic h, output logic [1:0] p,
                       output logic [63:0] o, output logic e);
    logic rh;
    rh = (a[63:12] == PAGE[63:12]) && (a[11:0] >= 12'h300) && (a[11:0] < 12'h3d8);
    h = 1'b0; p = '0; o = '0;
    for (int k = 3; k >= 0; k--) begin
      logic [31:0] sz;
      logic [63:0] eb;
      sz = (~sh[3*k+1][31:0] + 32'd1) & 32'hffff_f000;
      eb = {32'hffff_ffff, sh[3*k][31:12], 12'h000};
      if (sh[3*k][0] && sz != 0 && a >= eb && (a - eb) < {32'h0, sz}) begin
        h = 1'b1; p = sh[3*k+2][1:0]; o = a - eb;
      end
    end
    e = !rh && !h;
  endtask

  task automatic probe(logic [63:0] a, string tag);
    logic h, e;
    logic [1:0] p;
    logic [63:0] o;
    model(a, h, p, o, e);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_wide = 1'b1; acc_addr = a;
    #2;
    chk({tag, " R7 hit"}, 64'(win_hit), 64'(h));
    chk({tag, " R8 port"}, 64'(win_port), 64'(p));
    chk({tag, " R8 offset"}, win_offset, o);
    chk({tag, " R10 err"}, 64'(dec_err), 64'(e));
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] sz;
      logic [63:0] eb;
      sz = (~sh[3*k+1][31:0] + 32'd1) & 32'hffff_f000;
      eb = {32'hffff_ffff, sh[3*k][31:12], 12'h000};
      probe(eb - 1, tag);
      probe(eb, tag);
      probe(eb + {32'h0, sz >> 1}, tag);
      probe(eb + {32'h0, sz} - 1, tag);
      probe(eb + {32'h0, sz}, tag);
      probe({32'h0, eb[31:0]}, tag);
    end
    probe(PAGE + 64'h100, tag);
    probe(PAGE + 64'h3d8, tag);
    probe(PAGE + 64'h300, tag);
  endtask

  task automatic cfg(int k, logic [63:0] b, logic [63:0] m, logic [63:0] r);
    wr_reg(3*k, 1'b1, 1'b0, b);
    wr_reg(3*k+1, 1'b1, 1'b0, m);
    wr_reg(3*k+2, 1'b1, 1'b0, r);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    for (int i = 0; i < NREG; i++) sh[i] = '0;
    sh[13] = 64'h0000_0000_fc00_0000;
    sh[19] = 64'h0000_00ff_ffff_0000;
    sh[24] = 64'h0000_00ff_fee0_0000;
    sh[25] = 64'h0000_00ff_ffff_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: idle outputs
    @(negedge clk); #2;
    chk("R11 idle hit", 64'(win_hit), 64'd0);
    chk("R11 idle err", 64'(dec_err), 64'd0);

    // R1: reset values
    for (int i = 0; i < NREG; i++) begin
      rd(roff(i), 1'b1, d);
      chk($sformatf("R1 reset idx %0d", i), d, sh[i]);
    end

    // R2: wide write / read on every register
    for (int i = 0; i < NREG; i++)
      wr_reg(i, 1'b1, 1'b0, 64'ha5c3_0000_0000_0000 ^ (64'(i) * 64'h0001_0203_0405_0607));
    for (int i = 0; i < NREG; i++) begin
      rd(roff(i), 1'b1, d);
      chk($sformatf("R2 wide idx %0d", i), d, sh[i]);
    end

    // R3 / R4: half-word writes and reads
    for (int i = 0; i < NREG; i += 4) begin
      wr_reg(i, 1'b0, 1'b0, 64'hdead_beef_1234_5678 + 64'(i));
      rd(roff(i), 1'b1, d);
      chk($sformatf("R3 lo-write idx %0d", i), d, sh[i]);
      wr_reg(i, 1'b0, 1'b1, 64'h0000_0000_cafe_f00d ^ 64'(i));
      rd(roff(i), 1'b1, d);
      chk($sformatf("R3 hi-write idx %0d", i), d, sh[i]);
      rd(roff(i), 1'b0, d);
      chk($sformatf("R4 lo-read idx %0d", i), d, {32'h0, sh[i][31:0]});
      rd(roff(i) + 64'd4, 1'b0, d);
      chk($sformatf("R4 hi-read idx %0d", i), d, {32'h0, sh[i][63:32]});
    end

    // Clear all registers.
    for (int i = 0; i < NREG; i++) wr_reg(i, 1'b1, 1'b0, 64'h0);

    // Set A: overlap (R9), disabled (R5), zero size (R6)
    cfg(0, 64'h8000_0001, 64'hfff0_0000, 64'h2);
    cfg(1, 64'h8008_0001, 64'hffff_0000, 64'h1);
    cfg(2, 64'h9000_0000, 64'hfff0_0000, 64'h3);
    cfg(3, 64'ha000_0001, 64'h0,         64'h1);
    sweep("setA R5 R6 R9");

    // Set B: window 1 alone in the overlap, unaligned base and mask (R7)
    cfg(0, 64'h0, 64'hfff0_0000, 64'h2);
    wr_reg(6, 1'b0, 1'b0, 64'h9000_0abd);
    wr_reg(6, 1'b0, 1'b1, 64'h0000_0077);
    wr_reg(7, 1'b1, 1'b0, 64'hffff_e001);
    wr_reg(8, 1'b1, 1'b0, 64'hffff_fff3);
    cfg(3, 64'hc000_0001, 64'hf000_0000, 64'h7);
    sweep("setB R7 R8");

    // Set C: all four enabled, distinct ports
    cfg(0, 64'h4000_0001, 64'hffff_f000, 64'h0);
    cfg(1, 64'h4000_1001, 64'hffff_e000, 64'h1);
    cfg(2, 64'h4000_0001, 64'hffff_0000, 64'h2);
    cfg(3, 64'h5000_0001, 64'hff00_0000, 64'h3);
    sweep("setC R9");

    // R10: write to a non-register page offset changes nothing
    wr(PAGE + 64'h100, 1'b1, 64'hffff_ffff_ffff_ffff);
    // R11: write to a window address changes nothing
    wr(64'hffff_ffff_4000_0010, 1'b1, 64'h1111_2222_3333_4444);
    // R11: write data without valid is ignored
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b1; acc_wide = 1'b1;
    acc_addr = roff(0); acc_wdata = 64'h5555_5555_5555_5555;
    #2;
    chk("R11 no-valid hit", 64'(win_hit), 64'd0);
    chk("R11 no-valid err", 64'(dec_err), 64'd0);
    idle();
    for (int i = 0; i < NREG; i++) begin
      rd(roff(i), 1'b1, d);
      chk($sformatf("R10 R11 untouched idx %0d", i), d, sh[i]);
    end
    probe(PAGE + 64'h100, "R10 unmapped");
    rd(PAGE + 64'h100, 1'b1, d);
    chk("R10 unmapped rdata", d, 64'h0);
    chk("R10 unmapped reg_hit", 64'(acc_reg_hit), 64'd0);

    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule